// File: doc/BRIEF.md
# Indexed SRAM Access Port with Auto-Increment

This block gives a host a programmed-I/O path into a private byte-wide SRAM without any decoding outside the block. The host sees two ports. The pointer port holds a 16-bit SRAM address. The data port turns every host access into one or two SRAM byte cycles, which the block issues through a request/acknowledge interface to a private-bus sequencer. When the cycles finish, the pointer moves forward by the number of bytes transferred, so a host can stream through the SRAM by hitting the data port again and again.

The host side follows ISA-style byte-lane rules. A host access carries an address bit 0 and a high-byte enable. The block accepts a 16-bit cycle only when a configuration input allows it. It records whether a high-byte enable has been seen since reset, which tells it whether the bus is 8 or 16 bits wide. While a data-port access is in progress, the host waits.

Top module: `sram_port`

## Requirements
- R1: After synchronous reset the pointer is 0x0000, `host_ready` is 1, `err_flag`, `bus16` and `sram_req` are 0.
- R2: An even-byte data-port access (`host_a0`=0, `host_hbe`=0) runs one SRAM byte cycle at the pointer and moves data on lane [7:0]. The pointer then advances by 1. No odd byte needs to follow.
- R3: When `io16_en`=1, a word access (`host_a0`=0, `host_hbe`=1) to the data port runs two SRAM cycles: first the low byte at the pointer, then the high byte at pointer+1. The pointer advances by 2 after both cycles, and `mem16_resp` is 1 together with `host_done`.
- R4: When `io16_en`=0, a request with `host_a0`=0 and `host_hbe`=1 is handled as an even byte on lane [7:0]. The pointer advances by 1, `mem16_resp` stays 0, and the block arms acceptance of the odd half that follows.
- R5: An odd-byte data-port access (`host_a0`=1) that directly follows an armed split half runs one SRAM cycle at the pointer on lane [15:8]. The pointer then advances by 1.
- R6: An odd-byte data-port access that does not follow an armed split half runs no SRAM cycle and leaves the pointer unchanged. It sets `err_flag`, which stays set until reset.
- R7: On the pointer port (`host_port`=0), byte writes come in pairs. An even byte stages bits [7:0]. The odd byte that follows, with its data on lane [15:8], commits all 16 bits. An odd byte with no staged even byte is ignored and sets `err_flag`. Byte reads return the low byte on [7:0] and the high byte on [15:8].
- R8: The pointer wraps from 0xFFFF to 0x0000. A word at 0xFFFF uses addresses 0xFFFF and then 0x0000.
- R9: `bus16` becomes 1 on the first request with `host_hbe`=1 and stays 1 until reset. `mem16_resp` is never 1 while `bus16` is 0.
- R10: `host_ready` is 0 from the cycle after a request is accepted until `host_done` has pulsed. While an SRAM cycle waits for `sram_ack`, `sram_req` stays 1 and `sram_addr` does not change.
- R11: A pointer-port word write issued while a data-port transfer is in progress takes effect at once. It cancels that transfer's increment.
- R12: With `io16_en`=1, pointer-port word writes and reads move all 16 bits and give `mem16_resp`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io16_en | input | 1 | Allows 16-bit host cycles |
| host_req | input | 1 | One-cycle request strobe |
| host_port | input | 1 | 0 = pointer port, 1 = data port |
| host_we | input | 1 | 1 = write, 0 = read |
| host_a0 | input | 1 | Host address bit 0 |
| host_hbe | input | 1 | High-byte enable (active high) |
| host_wdata | input | 16 | Write data, low lane [7:0], high lane [15:8] |
| host_rdata | output | 16 | Read data, valid with host_done |
| host_ready | output | 1 | Block can accept a request |
| host_done | output | 1 | One-cycle completion pulse |
| mem16_resp | output | 1 | Completed access was a 16-bit cycle |
| bus16 | output | 1 | High-byte enable seen since reset |
| err_flag | output | 1 | Sticky byte-pairing violation |
| sram_req | output | 1 | SRAM byte cycle request |
| sram_we | output | 1 | SRAM cycle is a write |
| sram_addr | output | ADDR_W | SRAM byte address |
| sram_wdata | output | 8 | SRAM write byte |
| sram_rdata | input | 8 | SRAM read byte, valid with sram_ack |
| sram_ack | input | 1 | SRAM cycle complete |

## Verification
The bench targets the byte-lane corner cases. A lone odd byte on the data port must leave the SRAM untouched; a design that accepted it would show an extra SRAM cycle and a moved pointer. A host word split into two byte cycles must write the same bytes as a native word cycle; a design that used the wrong lane or advanced the pointer by the wrong amount would put the high byte at the wrong address. The word at 0xFFFF must wrap its second byte to 0x0000. A pointer write made during a transfer must survive, which a design that applied the increment after the write would break.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        ACC_EVEN = 2'd0,
        ACC_ODD  = 2'd1,
        ACC_WORD = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_DONE = 2'd3
    } st_e;

    typedef struct packed {
        acc_e kind;
        logic split_hint;
    } acc_t;

    localparam logic PORT_PTR  = 1'b0;
    localparam logic PORT_DATA = 1'b1;

    function automatic acc_t classify(input logic a0, input logic hbe, input logic io16);
        acc_t r;
        r.split_hint = 1'b0;
        if (a0)
            r.kind = ACC_ODD;
        else if (hbe && io16)
            r.kind = ACC_WORD;
        else begin
            r.kind       = ACC_EVEN;
            r.split_hint = hbe;
        end
        return r;
    endfunction

endpackage

// File: rtl/sp_decode.sv
module sp_decode
    import sp_pkg::*;
(
    input  logic a0,
    input  logic hbe,
    input  logic io16_en,
    output acc_t acc
);
    always_comb acc = classify(a0, hbe, io16_en);
endmodule

// File: rtl/sp_ptr.sv
module sp_ptr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              stage_en,
    input  logic [7:0]        stage_val,
    input  logic              inc_en,
    input  logic [1:0]        inc_amt,
    output logic [ADDR_W-1:0] ptr,
    output logic [7:0]        stage
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            stage <= '0;
        end else begin
            if (load_en)
                ptr <= load_val;
            else if (inc_en)
                ptr <= ptr + ADDR_W'(inc_amt);
            if (stage_en)
                stage <= stage_val;
        end
    end
endmodule

// File: rtl/sp_mode.sv
module sp_mode (
    input  logic clk,
    input  logic rst,
    input  logic hbe_seen,
    input  logic pair_set,
    input  logic pair_clr,
    input  logic split_set,
    input  logic split_clr,
    input  logic err_set,
    output logic bus16,
    output logic pair_pend,
    output logic split_pend,
    output logic err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus16      <= 1'b0;
            pair_pend  <= 1'b0;
            split_pend <= 1'b0;
            err        <= 1'b0;
        end else begin
            if (hbe_seen)  bus16 <= 1'b1;
            if (err_set)   err   <= 1'b1;
            if (pair_set)       pair_pend <= 1'b1;
            else if (pair_clr)  pair_pend <= 1'b0;
            if (split_set)      split_pend <= 1'b1;
            else if (split_clr) split_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sram_port.sv
module sram_port
    import sp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io16_en,
    input  logic              host_req,
    input  logic              host_port,
    input  logic              host_we,
    input  logic              host_a0,
    input  logic              host_hbe,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              host_ready,
    output logic              host_done,
    output logic              mem16_resp,
    output logic              bus16,
    output logic              err_flag,
    output logic              sram_req,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [7:0]        sram_wdata,
    input  logic [7:0]        sram_rdata,
    input  logic              sram_ack
);
    localparam int HOST_W = 16;

    st_e               state;
    acc_t              acc;
    logic [ADDR_W-1:0] ptr, base_q;
    logic [7:0]        stage;
    logic [15:0]       wdata_q, rdata_q, ptr_rd, ptr16;
    logic              word_q, hi_lane_q, we_q, skip_q;
    logic              pair_pend, split_pend;
    logic              idle_req, ptr_req, data_req, busy;
    logic              load_now, final_ack, odd_ok;
    logic [ADDR_W-1:0] load_val;

    sp_decode u_dec (
        .a0(host_a0), .hbe(host_hbe), .io16_en(io16_en), .acc(acc)
    );

    assign idle_req = host_req && (state == ST_IDLE);
    assign ptr_req  = idle_req && (host_port == PORT_PTR);
    assign data_req = idle_req && (host_port == PORT_DATA);
    assign busy     = (state == ST_LO) || (state == ST_HI);
    assign odd_ok   = (host_port == PORT_PTR) ? pair_pend : split_pend;
    assign ptr16    = HOST_W'(ptr);

    always_comb begin
        load_now = 1'b0;
        if (host_req && host_port == PORT_PTR && host_we) begin
            if (state == ST_IDLE)
                load_now = (acc.kind == ACC_WORD) || (acc.kind == ACC_ODD && pair_pend);
            else if (busy)
                load_now = (acc.kind == ACC_WORD);
        end
        load_val = (acc.kind == ACC_WORD) ? ADDR_W'(host_wdata)
                                          : ADDR_W'({host_wdata[15:8], stage});
        case (acc.kind)
            ACC_WORD: ptr_rd = ptr16;
            ACC_EVEN: ptr_rd = {8'h00, ptr16[7:0]};
            default:  ptr_rd = pair_pend ? {ptr16[15:8], 8'h00} : 16'h0000;
        endcase
    end

    assign final_ack = sram_ack && ((state == ST_LO && !word_q) || state == ST_HI);

    sp_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst),
        .load_en(load_now), .load_val(load_val),
        .stage_en(ptr_req && host_we && acc.kind == ACC_EVEN),
        .stage_val(host_wdata[7:0]),
        .inc_en(final_ack && !skip_q && !load_now),
        .inc_amt(word_q ? 2'd2 : 2'd1),
        .ptr(ptr), .stage(stage)
    );

    sp_mode u_mode (
        .clk(clk), .rst(rst),
        .hbe_seen(host_req && host_hbe),
        .pair_set(ptr_req && acc.kind == ACC_EVEN),
        .pair_clr(ptr_req && acc.kind != ACC_EVEN),
        .split_set(data_req && acc.kind == ACC_EVEN && acc.split_hint),
        .split_clr(data_req && !(acc.kind == ACC_EVEN && acc.split_hint)),
        .err_set(idle_req && acc.kind == ACC_ODD && !odd_ok),
        .bus16(bus16), .pair_pend(pair_pend), .split_pend(split_pend), .err(err_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            base_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            word_q    <= 1'b0;
            hi_lane_q <= 1'b0;
            we_q      <= 1'b0;
            skip_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    skip_q <= 1'b0;
                    if (host_req) begin
                        rdata_q   <= '0;
                        word_q    <= (acc.kind == ACC_WORD);
                        hi_lane_q <= (acc.kind == ACC_ODD);
                        we_q      <= host_we;
                        wdata_q   <= host_wdata;
                        base_q    <= ptr;
                        if (host_port == PORT_PTR) begin
                            state <= ST_DONE;
                            if (!host_we) rdata_q <= ptr_rd;
                        end else if (acc.kind == ACC_ODD && !split_pend)
                            state <= ST_DONE;
                        else
                            state <= ST_LO;
                    end
                end
                ST_LO: begin
                    if (load_now) skip_q <= 1'b1;
                    if (sram_ack) begin
                        if (hi_lane_q) rdata_q[15:8] <= sram_rdata;
                        else           rdata_q[7:0]  <= sram_rdata;
                        state <= word_q ? ST_HI : ST_DONE;
                    end
                end
                ST_HI: begin
                    if (load_now) skip_q <= 1'b1;
                    if (sram_ack) begin
                        rdata_q[15:8] <= sram_rdata;
                        state         <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign host_ready = (state == ST_IDLE);
    assign host_done  = (state == ST_DONE);
    assign host_rdata = rdata_q;
    assign mem16_resp = host_done && word_q;
    assign sram_req   = busy;
    assign sram_we    = we_q;
    assign sram_addr  = (state == ST_HI) ? base_q + ADDR_W'(1) : base_q;
    assign sram_wdata = (state == ST_HI || hi_lane_q) ? wdata_q[15:8] : wdata_q[7:0];
endmodule

// File: rtl/sram_port_checker.sv
module sram_port_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              host_ready,
    input logic              host_done,
    input logic              mem16_resp,
    input logic              bus16,
    input logic              err_flag,
    input logic              sram_req,
    input logic              sram_ack,
    input logic [ADDR_W-1:0] sram_addr
);
    a_r10_req_not_ready: assert property (@(posedge clk) disable iff (rst)
        sram_req |-> !host_ready);
    a_r10_done_not_ready: assert property (@(posedge clk) disable iff (rst)
        host_done |-> !host_ready);
    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        (sram_req && !sram_ack) |=> (sram_req && $stable(sram_addr)));
    a_r9_bus16_sticky: assert property (@(posedge clk) disable iff (rst)
        bus16 |=> bus16);
    a_r9_no_wide_resp: assert property (@(posedge clk) disable iff (rst)
        !bus16 |-> !mem16_resp);
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);
    a_r3_wide_with_done: assert property (@(posedge clk) disable iff (rst)
        mem16_resp |-> host_done);
endmodule

bind sram_port sram_port_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .host_ready(host_ready), .host_done(host_done),
    .mem16_resp(mem16_resp), .bus16(bus16), .err_flag(err_flag),
    .sram_req(sram_req), .sram_ack(sram_ack), .sram_addr(sram_addr)
);

// File: tb/tb_sram_port.sv
`timescale 1ns/1ps
module tb_sram_port;
    localparam int ADDR_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic io16_en = 1'b0;
    logic host_req = 1'b0, host_port = 1'b0, host_we = 1'b0, host_a0 = 1'b0, host_hbe = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic host_ready, host_done, mem16_resp, bus16, err_flag;
    logic sram_req, sram_we, sram_ack;
    logic [ADDR_W-1:0] sram_addr;
    logic [7:0] sram_wdata, sram_rdata;

    int errors = 0;
    int checks = 0;
    int ncyc = 0;
    int viol = 0;
    int m16_seen = 0;
    int seq_cnt = 0;
    logic [15:0] alog [0:7];
    logic [7:0]  mem [0:255];

    always #4 clk = ~clk;

    sram_port #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .io16_en(io16_en),
        .host_req(host_req), .host_port(host_port), .host_we(host_we),
        .host_a0(host_a0), .host_hbe(host_hbe), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready), .host_done(host_done),
        .mem16_resp(mem16_resp), .bus16(bus16), .err_flag(err_flag),
        .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .sram_ack(sram_ack)
    );

    // private-bus sequencer model: acknowledges after two cycles of request
    initial begin
        sram_ack   = 1'b0;
        sram_rdata = '0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5C);
    end
    always @(posedge clk) begin
        if (rst) begin
            sram_ack <= 1'b0;
            seq_cnt  <= 0;
        end else if (sram_ack) begin
            sram_ack <= 1'b0;
            seq_cnt  <= 0;
        end else if (sram_req) begin
            if (seq_cnt == 1) begin
                sram_ack   <= 1'b1;
                sram_rdata <= mem[sram_addr[7:0]];
                if (sram_we) mem[sram_addr[7:0]] <= sram_wdata;
                alog[ncyc[2:0]] <= sram_addr;
                ncyc       <= ncyc + 1;
                seq_cnt    <= 0;
            end else
                seq_cnt <= seq_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && sram_req && host_ready) viol++;
        if (!rst && mem16_resp) m16_seen++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic access(input logic port, input logic we, input logic a0, input logic hbe,
                          input logic [15:0] wd, output logic [15:0] rd, output logic m16);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_port = port; host_we = we;
        host_a0 = a0; host_hbe = hbe; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0; host_hbe = 1'b0;
        while (!host_done) @(negedge clk);
        rd  = host_rdata;
        m16 = mem16_resp;
    endtask

    task automatic set_ptr(input logic [15:0] v);
        logic [15:0] rd; logic m;
        access(1'b0, 1'b1, 1'b0, 1'b0, {8'h00, v[7:0]}, rd, m);
        access(1'b0, 1'b1, 1'b1, 1'b0, {v[15:8], 8'h00}, rd, m);
    endtask

    task automatic get_ptr(output logic [15:0] v);
        logic [15:0] rd; logic m;
        access(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, rd, m);
        v[7:0] = rd[7:0];
        access(1'b0, 1'b0, 1'b1, 1'b0, 16'h0, rd, m);
        v[15:8] = rd[15:8];
    endtask

    task automatic t_reset();
        logic [15:0] p;
        chk(host_ready === 1'b1, "R1 ready", int'(host_ready), 1);
        chk(err_flag === 1'b0 && bus16 === 1'b0, "R1 flags", int'({err_flag, bus16}), 0);
        chk(sram_req === 1'b0, "R1 sram_req", int'(sram_req), 0);
        get_ptr(p);
        chk(p == 16'h0000, "R1 pointer", int'(p), 0);
    endtask

    task automatic t_ptr_pair();
        logic [15:0] p, rd; logic m;
        set_ptr(16'h1234);
        get_ptr(p);
        chk(p == 16'h1234, "R7 paired write", int'(p), 'h1234);
        access(1'b0, 1'b1, 1'b1, 1'b0, 16'hAB00, rd, m);
        get_ptr(p);
        chk(p == 16'h1234, "R7 lone odd ignored", int'(p), 'h1234);
        chk(err_flag === 1'b1, "R7 lone odd error", int'(err_flag), 1);
    endtask

    task automatic t_even();
        logic [15:0] p, rd; logic m; int c0;
        set_ptr(16'h0010);
        c0 = ncyc;
        access(1'b1, 1'b1, 1'b0, 1'b0, 16'h77A5, rd, m);
        chk(ncyc == c0 + 1, "R2 one cycle", ncyc - c0, 1);
        chk(mem[8'h10] == 8'hA5, "R2 low lane written", int'(mem[8'h10]), 'hA5);
        get_ptr(p);
        chk(p == 16'h0011, "R2 pointer +1", int'(p), 'h11);
        set_ptr(16'h0010);
        access(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, rd, m);
        chk(rd == 16'h00A5, "R2 read low lane", int'(rd), 'hA5);
        get_ptr(p);
        chk(p == 16'h0011, "R2 read pointer +1", int'(p), 'h11);
    endtask

    task automatic t_lone_odd();
        logic [15:0] p, rd; logic m; int c0;
        c0 = ncyc;
        access(1'b1, 1'b1, 1'b1, 1'b0, 16'hEE00, rd, m);
        chk(ncyc == c0, "R6 no SRAM cycle", ncyc - c0, 0);
        chk(err_flag === 1'b1, "R6 error set", int'(err_flag), 1);
        get_ptr(p);
        chk(p == 16'h0011, "R6 pointer held", int'(p), 'h11);
        chk(mem[8'h11] == 8'(8'h11 ^ 8'h5C), "R6 SRAM untouched", int'(mem[8'h11]), int'(8'h11 ^ 8'h5C));
        chk(err_flag === 1'b1, "R6 error sticky", int'(err_flag), 1);
        chk(bus16 === 1'b0 && m16_seen == 0, "R9 narrow bus", int'(bus16), 0);
    endtask

    task automatic t_split();
        logic [15:0] p, rd; logic m;
        io16_en = 1'b0;
        set_ptr(16'h0020);
        access(1'b1, 1'b1, 1'b0, 1'b1, 16'h3C5A, rd, m);
        chk(mem[8'h20] == 8'h5A && m == 1'b0, "R4 split low half", int'(mem[8'h20]), 'h5A);
        chk(bus16 === 1'b1, "R9 bus16 latched", int'(bus16), 1);
        access(1'b1, 1'b1, 1'b1, 1'b1, 16'h3C00, rd, m);
        chk(mem[8'h21] == 8'h3C, "R5 odd half high lane", int'(mem[8'h21]), 'h3C);
        chk(err_flag === 1'b0, "R5 no error", int'(err_flag), 0);
        get_ptr(p);
        chk(p == 16'h0022, "R5 pointer +2 total", int'(p), 'h22);
        set_ptr(16'h0020);
        access(1'b1, 1'b0, 1'b0, 1'b1, 16'h0, rd, m);
        chk(rd[7:0] == 8'h5A, "R4 split read low", int'(rd[7:0]), 'h5A);
        access(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, rd, m);
        chk(rd[15:8] == 8'h3C, "R5 split read high", int'(rd[15:8]), 'h3C);
        chk(m16_seen == 0, "R4 no wide response", m16_seen, 0);
    endtask

    task automatic t_word();
        logic [15:0] p, rd; logic m; int c0;
        io16_en = 1'b1;
        set_ptr(16'h0030);
        c0 = ncyc;
        access(1'b1, 1'b1, 1'b0, 1'b1, 16'hBEEF, rd, m);
        chk(m == 1'b1, "R3 wide response", int'(m), 1);
        chk(ncyc == c0 + 2, "R3 two cycles", ncyc - c0, 2);
        chk(alog[c0[2:0]] == 16'h0030 && alog[3'(c0 + 1)] == 16'h0031, "R3 address order",
            int'(alog[c0[2:0]]), 'h30);
        chk(mem[8'h30] == 8'hEF && mem[8'h31] == 8'hBE, "R3 bytes", int'({mem[8'h31], mem[8'h30]}), 'hBEEF);
        get_ptr(p);
        chk(p == 16'h0032, "R3 pointer +2", int'(p), 'h32);
        set_ptr(16'h0030);
        access(1'b1, 1'b0, 1'b0, 1'b1, 16'h0, rd, m);
        chk(rd == 16'hBEEF, "R3 word read", int'(rd), 'hBEEF);
    endtask

    task automatic t_wrap();
        logic [15:0] p, rd; logic m; int c0;
        set_ptr(16'hFFFF);
        access(1'b1, 1'b1, 1'b0, 1'b0, 16'h0011, rd, m);
        get_ptr(p);
        chk(p == 16'h0000 && mem[8'hFF] == 8'h11, "R8 byte wrap", int'(p), 0);
        set_ptr(16'hFFFF);
        c0 = ncyc;
        access(1'b1, 1'b1, 1'b0, 1'b1, 16'h2233, rd, m);
        chk(alog[3'(c0 + 1)] == 16'h0000, "R8 second address wraps", int'(alog[3'(c0 + 1)]), 0);
        chk(mem[8'hFF] == 8'h33 && mem[8'h00] == 8'h22, "R8 word wrap bytes", int'({mem[8'h00], mem[8'hFF]}), 'h2233);
        get_ptr(p);
        chk(p == 16'h0001, "R8 pointer after wrap", int'(p), 1);
    endtask

    task automatic t_busy();
        @(negedge clk);
        host_req = 1'b1; host_port = 1'b1; host_we = 1'b0; host_a0 = 1'b0; host_hbe = 1'b0;
        @(negedge clk);
        host_req = 1'b0;
        chk(host_ready === 1'b0 && sram_req === 1'b1, "R10 waiting", int'({host_ready, sram_req}), 1);
        while (!host_done) @(negedge clk);
        chk(host_ready === 1'b0, "R10 not ready at done", int'(host_ready), 0);
        @(negedge clk);
        chk(host_ready === 1'b1, "R10 ready after done", int'(host_ready), 1);
        chk(viol == 0, "R10 no request while ready", viol, 0);
    endtask

    task automatic t_override();
        logic [15:0] p;
        io16_en = 1'b1;
        set_ptr(16'h0040);
        @(negedge clk);
        host_req = 1'b1; host_port = 1'b1; host_we = 1'b1; host_a0 = 1'b0; host_hbe = 1'b0;
        host_wdata = 16'h0066;
        @(negedge clk);
        host_port = 1'b0; host_we = 1'b1; host_a0 = 1'b0; host_hbe = 1'b1; host_wdata = 16'h0100;
        @(negedge clk);
        host_req = 1'b0; host_hbe = 1'b0;
        while (!host_done) @(negedge clk);
        chk(mem[8'h40] == 8'h66, "R11 transfer completed", int'(mem[8'h40]), 'h66);
        get_ptr(p);
        chk(p == 16'h0100, "R11 write beats increment", int'(p), 'h100);
    endtask

    task automatic t_ptr_word();
        logic [15:0] rd; logic m;
        io16_en = 1'b1;
        access(1'b0, 1'b1, 1'b0, 1'b1, 16'h4321, rd, m);
        chk(m == 1'b1, "R12 wide write response", int'(m), 1);
        access(1'b0, 1'b0, 1'b0, 1'b1, 16'h0, rd, m);
        chk(rd == 16'h4321 && m == 1'b1, "R12 word read", int'(rd), 'h4321);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ptr_pair();
        do_reset();
        t_even();
        t_lone_odd();
        do_reset();
        t_split();
        t_word();
        t_wrap();
        t_busy();
        t_override();
        t_ptr_word();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule